// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block forms the internal word address of a synchronous SRAM during four-beat bursts. The upper address bits are captured from the external address bus when a burst starts. The two low bits come from a small state machine that counts beats. From the starting low bits and the beat number, it produces either a linear or an interleaved sequence. The sequence stays inside one aligned four-word block and never carries into the upper bits.

A burst starts on a clock edge where one of two address strobes is asserted. The controller-side strobe always loads. The processor-side strobe loads only while the active-low chip enable is asserted. When both strobes are active, the controller-side strobe takes the load. After the load, the address steps only on edges where the active-low advance input is asserted. A new load may happen on any cycle, so a user can ignore bursts and present a fresh address every cycle. The order input is sampled at the load and is held for the whole burst.

The beat state machine has five states. The states are:
- `ST_IDLE`: no burst has been loaded since reset.
- `ST_BEAT0`, `ST_BEAT1`, `ST_BEAT2`, `ST_BEAT3`: the current beat number.

The transitions are:
- `LOAD`: from any state to `ST_BEAT0`.
- `STEP`: from `ST_BEATn` to `ST_BEATn+1`.
- `WRAP`: from `ST_BEAT3` to `ST_BEAT0`.
- `HOLD`: the state stays the same when neither a load nor an advance is present.
- `IDLE_IGNORE`: an advance in `ST_IDLE` leaves the state in `ST_IDLE`.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, and before any load, `addr_out` is all zeros.
- R2: A rising clock edge with `ctl_strobe_n` low loads `addr_in` into `addr_out`, whatever the level of `chip_en_n`. The new value is visible after that edge.
- R3: An edge with `cpu_strobe_n` low loads `addr_in` only if `chip_en_n` is low at the same edge. If `chip_en_n` is high, `addr_out` keeps its value.
- R4: When both strobes are low at the same edge, the controller-side strobe wins. The load therefore takes place even with `chip_en_n` high.
- R5: If `order_lin_n` is low at the load, the low two bits at beat k are (start + k) mod 4.
- R6: If `order_lin_n` is high at the load, the low two bits at beat k are start XOR k.
- R7: An edge with no load and `advance_n` high leaves `addr_out` unchanged.
- R8: The advance after beat 3 returns to beat 0, which gives the starting low bits again. The upper bits `addr_out[ADDR_W-1:2]` never change without a load.
- R9: `advance_n` low before any load has been made has no effect, and `addr_out` stays zero.
- R10: A load during a burst restarts the sequence at beat 0 from the new address.
- R11: Changing `order_lin_n` during a burst does not change the order in use until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | External address |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low, priority |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, qualified by chip enable |
| chip_en_n | input | 1 | Chip enable, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_lin_n | input | 1 | Burst order: low selects linear, high selects interleaved |
| addr_out | output | ADDR_W | Internal address: captured upper bits plus the generated low two bits |

## Verification
Bursts start from each of the four low-bit values, so that linear order (with a carry across bit 1) and interleaved order (with the XOR pattern) produce different sequences. The upper bits are set to all ones, so that any carry out of the low field would show. Strobe combinations are applied with chip enable both high and low. These separate the gated processor-side load from the controller-side load, and from the case where both are active. Further sequences stall the advance, advance before any load, reload in the middle of a burst, and toggle the order input in the middle of a burst. These show that the state is held, that idle advances are ignored, that a reload restarts the count, and that the order was captured at the load.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;
    localparam int LOW_W = 2;
    localparam int BEATS = 1 << LOW_W;

    typedef logic [LOW_W-1:0] low_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } beat_state_t;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_CTL  = 2'd1,
        LD_CPU  = 2'd2
    } load_src_t;
endpackage

// File: rtl/bas_load_arbiter.sv
module bas_load_arbiter
    import burst_addr_seq_pkg::*;
(
    input  logic      ctl_strobe_n,
    input  logic      cpu_strobe_n,
    input  logic      chip_en_n,
    output load_src_t load_src,
    output logic      load
);
    always_comb begin
        if (!ctl_strobe_n)
            load_src = LD_CTL;
        else if (!cpu_strobe_n && !chip_en_n)
            load_src = LD_CPU;
        else
            load_src = LD_NONE;
    end

    assign load = (load_src != LD_NONE);
endmodule

// File: rtl/bas_beat_fsm.sv
module bas_beat_fsm
    import burst_addr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic advance,
    output low_t beat,
    output logic active
);
    beat_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else if (advance) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        beat   = '0;
        active = 1'b1;
        unique case (state_q)
            ST_IDLE:  begin beat = 2'd0; active = 1'b0; end
            ST_BEAT0: beat = 2'd0;
            ST_BEAT1: beat = 2'd1;
            ST_BEAT2: beat = 2'd2;
            ST_BEAT3: beat = 2'd3;
            default:  begin beat = 2'd0; active = 1'b0; end
        endcase
    end

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT3 && advance && !load) |=> state_q == ST_BEAT0);

    // R9
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> state_q == ST_IDLE);
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
    import burst_addr_seq_pkg::*;
(
    input  low_t start,
    input  low_t beat,
    input  logic linear,
    output low_t low
);
    low_t lin_val, ilv_val;

    assign lin_val = low_t'(start + beat);

    for (genvar i = 0; i < LOW_W; i++) begin : g_xor
        assign ilv_val[i] = start[i] ^ beat[i];
    end

    assign low = linear ? lin_val : ilv_val;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ctl_strobe_n,
    input  logic              cpu_strobe_n,
    input  logic              chip_en_n,
    input  logic              advance_n,
    input  logic              order_lin_n,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - LOW_W;

    load_src_t         load_src;
    logic              load;
    low_t              beat;
    logic              active;
    low_t              low;
    logic [UP_W-1:0]   upper_q;
    low_t              start_q;
    logic              linear_q;

    bas_load_arbiter u_arb (
        .ctl_strobe_n (ctl_strobe_n),
        .cpu_strobe_n (cpu_strobe_n),
        .chip_en_n    (chip_en_n),
        .load_src     (load_src),
        .load         (load)
    );

    bas_beat_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (!advance_n),
        .beat    (beat),
        .active  (active)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upper_q  <= '0;
            start_q  <= '0;
            linear_q <= 1'b0;
        end else if (load) begin
            upper_q  <= addr_in[ADDR_W-1:LOW_W];
            start_q  <= addr_in[LOW_W-1:0];
            linear_q <= !order_lin_n;
        end
    end

    bas_order_map u_map (
        .start  (start_q),
        .beat   (beat),
        .linear (linear_q),
        .low    (low)
    );

    assign addr_out = {upper_q, low};

    // R2
    ctl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_strobe_n |=> addr_out == $past(addr_in));

    // R3
    cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_strobe_n && !cpu_strobe_n && chip_en_n && advance_n) |=> $stable(addr_out));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_src == LD_NONE && advance_n) |=> $stable(addr_out));

    // R8
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:LOW_W]));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && linear_q && !advance_n && !load) |=>
            addr_out[LOW_W-1:0] == low_t'($past(addr_out[LOW_W-1:0]) + 2'd1));
endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ctl_strobe_n = 1'b1;
    logic          cpu_strobe_n = 1'b1;
    logic          chip_en_n = 1'b1;
    logic          advance_n = 1'b1;
    logic          order_lin_n = 1'b1;
    logic [AW-1:0] addr_out;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .ctl_strobe_n(ctl_strobe_n), .cpu_strobe_n(cpu_strobe_n),
        .chip_en_n(chip_en_n), .advance_n(advance_n),
        .order_lin_n(order_lin_n), .addr_out(addr_out)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        total++;
        if (addr_out !== exp) begin
            bad++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // drive at negedge, one rising edge, return at following negedge
    task automatic step(input logic ctl, input logic cpu, input logic ce,
                        input logic adv, input logic lin, input logic [AW-1:0] a);
        ctl_strobe_n = ctl; cpu_strobe_n = cpu; chip_en_n = ce;
        advance_n = adv; order_lin_n = lin; addr_in = a;
        @(posedge clk);
        @(negedge clk);
        ctl_strobe_n = 1'b1; cpu_strobe_n = 1'b1; advance_n = 1'b1;
    endtask

    function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] s,
                                               input int k, input bit lin);
        logic [1:0] lo;
        lo = lin ? 2'(s[1:0] + 2'(k)) : (s[1:0] ^ 2'(k));
        return {s[AW-1:2], lo};
    endfunction

    task automatic t_reset();
        check("R1", '0);
        step(1, 1, 1, 0, 1, 20'hABCDE);
        check("R9", '0);
        step(1, 1, 1, 0, 0, 20'h12345);
        check("R9", '0);
    endtask

    task automatic t_strobes();
        step(0, 1, 1, 1, 1, 20'h12345);
        check("R2", 20'h12345);
        step(1, 0, 1, 1, 1, 20'h54321);
        check("R3", 20'h12345);
        step(1, 0, 0, 1, 1, 20'h54321);
        check("R3", 20'h54321);
        step(0, 0, 1, 1, 1, 20'h0F0F3);
        check("R4", 20'h0F0F3);
    endtask

    task automatic t_order(input bit lin);
        for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] base;
            base = {18'h3FFFF, 2'(s)};
            step(0, 1, 1, 1, lin ? 1'b0 : 1'b1, base);
            check(lin ? "R5" : "R6", base);
            for (int k = 1; k <= 4; k++) begin
                step(1, 1, 1, 0, 1, '0);
                check(k == 4 ? "R8" : (lin ? "R5" : "R6"), seq_addr(base, k % 4, lin));
            end
        end
    endtask

    task automatic t_hold();
        step(1, 0, 0, 1, 0, 20'h00402);
        step(1, 1, 1, 0, 1, '0);
        check("R5", 20'h00403);
        step(1, 1, 1, 1, 1, '0);
        check("R7", 20'h00403);
        step(1, 0, 1, 1, 1, 20'h99999);
        check("R7", 20'h00403);
    endtask

    task automatic t_restart();
        step(0, 1, 1, 1, 1, 20'h11112);
        step(1, 1, 1, 0, 1, '0);
        check("R6", 20'h11113);
        step(0, 1, 1, 1, 0, 20'h22221);
        check("R10", 20'h22221);
        step(1, 1, 1, 0, 0, '0);
        check("R10", 20'h22222);
    endtask

    task automatic t_order_latch();
        step(0, 1, 1, 1, 1, 20'h33331);
        step(1, 1, 1, 0, 0, '0);
        check("R11", 20'h33330);
        step(1, 1, 1, 0, 0, '0);
        check("R11", 20'h33333);
    endtask

    initial begin
        #1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strobes();
        t_order(1'b1);
        t_order(1'b0);
        t_hold();
        t_restart();
        t_order_latch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule